// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-clock synchronous static memory. Each word is 36 bits wide and is split into four 9-bit lanes. Every input is captured in a register on the rising clock edge. This covers the address, write data, the three select inputs and the write controls. The memory access then runs on the registered values. A write updates the lanes chosen by a two-level write decode. For a read, the array output is held in a pipeline register that drives `dout`, and a driver-enable flag marks when the output would be driven onto a shared bus.

The write decode works in two levels. A global write strobe forces all four lanes to be written. When the global strobe is idle, a lane-write enable allows four per-lane strobes to choose lanes one at a time. Three select inputs with mixed polarity let several of these blocks share an address range for depth expansion. An asynchronous output enable masks the driver flag without changing the data held in the pipeline. The depth is a parameter, so the block can be simulated at small sizes.

Top module: `bytewr_sram`

## Requirements
- R1: A word holds four 9-bit lanes at fixed bit positions: lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27.
- R2: For a read presented before rising edge N, the data is on `dout` and `dout_drive` is high after edge N+1, provided `out_en_n` is low.
- R3: When `wr_all_n` is high and `lane_wr_en_n` is low, lane i is written only if `lane_wr_n[i]` is low. The other lanes keep their contents.
- R4: When `wr_all_n` is low, all four lanes are written, whatever `lane_wr_en_n` and `lane_wr_n` hold.
- R5: A selected cycle is a read, and changes no lane, in two cases. The first is `wr_all_n` high with `lane_wr_en_n` high. The second is `wr_all_n` high with `lane_wr_en_n` low and all four `lane_wr_n` bits high.
- R6: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A cycle that is not selected writes nothing, and `dout_drive` is low in its output slot.
- R7: A selected write cycle leaves `dout_drive` low in its output slot.
- R8: `out_en_n` high forces `dout_drive` low at once, without a clock edge, and `dout` is left unchanged. When `out_en_n` returns low, the same data is driven again.
- R9: Reads issued on consecutive cycles return their data on consecutive cycles, one word per cycle.
- R10: The synchronous active-high `rst` clears `dout_drive` and the pending access, but does not clear the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs1_n | input | 1 | Select, active low |
| cs2 | input | 1 | Select, active high |
| cs3_n | input | 1 | Select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane write strobes, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, bit i for lane i, active low |
| addr | input | AW | Word address |
| din | input | 36 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Registered read data |
| dout_drive | output | 1 | Output driver enable |

## Verification
The hardest case to reach from the ports is a partial-lane write whose effect can be seen at all. Each lane that a given strobe pattern leaves alone must already hold a value that differs from the new data. The bench therefore first fills every address with a lane-distinct pattern using global writes. It then applies each of the 64 combinations of global write, lane-write enable and lane strobes to its own address, using the complement of that pattern, and reads every word back against a lane-wise model. The three select inputs get the same exhaustive treatment over all eight combinations, for both writes and reads.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bwsram_wctl.sv
module bwsram_wctl
  import bwsram_pkg::*;
(
  input  logic       cs1_n,
  input  logic       cs2,
  input  logic       cs3_n,
  input  logic       wr_all_n,
  input  logic       lane_wr_en_n,
  input  lane_mask_t lane_wr_n,
  output logic       selected,
  output lane_mask_t wr_mask,
  output logic       rd_access
);
  lane_mask_t raw_mask;

  always_comb begin
    if (!wr_all_n)          raw_mask = '1;
    else if (!lane_wr_en_n) raw_mask = ~lane_wr_n;
    else                    raw_mask = '0;
  end

  assign selected  = !cs1_n && cs2 && !cs3_n;
  assign wr_mask   = selected ? raw_mask : '0;
  assign rd_access = selected && (raw_mask == '0);
endmodule

// File: rtl/bwsram_core.sv
module bwsram_core
  import bwsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  lane_mask_t        wr_mask,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end

  // R5/R7: the pipeline register only moves on read cycles
  a_r7_hold_on_nonread: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/bytewr_sram.sv
module bytewr_sram
  import bwsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] din,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] dout,
  output logic              dout_drive
);
  logic              cs1_n_q, cs2_q, cs3_n_q, wr_all_n_q, lane_wr_en_n_q;
  lane_mask_t        lane_wr_n_q;
  logic [AW-1:0]     addr_q;
  logic [WORD_W-1:0] din_q;
  logic              selected, rd_access, valid_q;
  lane_mask_t        wr_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs1_n_q        <= 1'b1;
      cs2_q          <= 1'b0;
      cs3_n_q        <= 1'b1;
      wr_all_n_q     <= 1'b1;
      lane_wr_en_n_q <= 1'b1;
      lane_wr_n_q    <= '1;
    end else begin
      cs1_n_q        <= cs1_n;
      cs2_q          <= cs2;
      cs3_n_q        <= cs3_n;
      wr_all_n_q     <= wr_all_n;
      lane_wr_en_n_q <= lane_wr_en_n;
      lane_wr_n_q    <= lane_wr_n;
    end
    addr_q <= addr;
    din_q  <= din;
  end

  bwsram_wctl u_wctl (
    .cs1_n        (cs1_n_q),
    .cs2          (cs2_q),
    .cs3_n        (cs3_n_q),
    .wr_all_n     (wr_all_n_q),
    .lane_wr_en_n (lane_wr_en_n_q),
    .lane_wr_n    (lane_wr_n_q),
    .selected     (selected),
    .wr_mask      (wr_mask),
    .rd_access    (rd_access)
  );

  bwsram_core #(.DEPTH(DEPTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr_q),
    .wdata   (din_q),
    .wr_mask (wr_mask),
    .rd_en   (rd_access),
    .rd_q    (dout)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= rd_access;
  end

  assign dout_drive = valid_q && !out_en_n;

  logic sel_in;
  assign sel_in = !cs1_n && cs2 && !cs3_n;

  a_r6_desel_no_drive: assert property (@(posedge clk) disable iff (rst)
    !sel_in |=> ##1 !valid_q);
  a_r7_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    sel_in && (!wr_all_n || (!lane_wr_en_n && lane_wr_n != '1)) |=> ##1 !valid_q);
  a_r5_read_drives: assert property (@(posedge clk) disable iff (rst)
    sel_in && wr_all_n && lane_wr_en_n |=> ##1 valid_q);
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !valid_q);
  a_r8_oe_masks: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dout_drive);
endmodule

// File: tb/tb_bytewr_sram.sv
module tb_bytewr_sram;
  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic        wr_all_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0] din = '0;
  logic        out_en_n = 1'b0;
  logic [35:0] dout;
  logic        dout_drive;

  int n_chk = 0, n_bad = 0;
  logic [35:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  bytewr_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .din(din), .out_en_n(out_en_n),
    .dout(dout), .dout_drive(dout_drive)
  );

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic issue(logic [2:0] ce, logic gw, logic bwe, logic [3:0] bw,
                       logic [AW-1:0] a, logic [35:0] d);
    {cs1_n, cs2, cs3_n} = ce;
    wr_all_n = gw; lane_wr_en_n = bwe; lane_wr_n = bw;
    addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    issue(3'b100, 1'b1, 1'b1, 4'hF, '0, '0);
  endtask

  function automatic logic [35:0] pre_pat(int i);
    return {9'(i + 1), 9'(i + 70), 9'(i + 140), 9'(i + 210)};
  endfunction

  function automatic logic [3:0] exp_mask(logic gw, logic bwe, logic [3:0] bw);
    if (!gw) return 4'hF;
    if (!bwe) return ~bw;
    return 4'h0;
  endfunction

  task automatic read_check(string req, int a);
    issue(3'b010, 1'b1, 1'b1, 4'hF, AW'(a), '0);
    idle();
    check(req, {35'd0, dout_drive}, 36'd1);
    check(req, dout, ref_mem[a]);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset drive", {35'd0, dout_drive}, 36'd0);
    rst = 1'b0;
    @(negedge clk);

    // prefill every word with a lane-distinct pattern via global write (R4)
    for (int i = 0; i < DEPTH; i++) begin
      issue(3'b010, 1'b0, 1'b1, 4'hF, AW'(i), pre_pat(i));
      ref_mem[i] = pre_pat(i);
    end
    idle();
    for (int i = 0; i < DEPTH; i++) read_check("R4 R2 prefill", i);

    // every combination of global write, lane-write enable and lane strobes (R1 R3 R4 R5 R7)
    for (int c = 0; c < 64; c++) begin
      logic gw, bwe;
      logic [3:0] bw, m;
      logic [35:0] nd;
      gw = c[5]; bwe = c[4]; bw = c[3:0];
      m = exp_mask(gw, bwe, bw);
      nd = ~pre_pat(c);
      issue(3'b010, gw, bwe, bw, AW'(c), nd);
      idle();
      if (m == 4'h0) begin
        check("R5 read-combo drive", {35'd0, dout_drive}, 36'd1);
        check("R5 read-combo data", dout, ref_mem[c]);
      end else begin
        check("R7 write slot drive", {35'd0, dout_drive}, 36'd0);
      end
      for (int l = 0; l < 4; l++)
        if (m[l]) ref_mem[c][l*9 +: 9] = nd[l*9 +: 9];
    end
    for (int c = 0; c < 64; c++) read_check("R1 R3 R4 R5 readback", c);

    // select combinations (R6)
    for (int k = 0; k < 8; k++) begin
      issue(3'(k), 1'b0, 1'b1, 4'hF, AW'(k), 36'hA5A5A5A5A ^ 36'(k));
      idle();
      check("R6 write slot drive", {35'd0, dout_drive}, 36'd0);
      if (k == 3'b010) ref_mem[k] = 36'hA5A5A5A5A ^ 36'(k);
      if (k != 3'b010) begin
        issue(3'(k), 1'b1, 1'b1, 4'hF, AW'(k), '0);
        idle();
        check("R6 deselected read drive", {35'd0, dout_drive}, 36'd0);
      end
    end
    for (int k = 0; k < 8; k++) read_check("R6 readback", k);

    // back-to-back reads (R9)
    issue(3'b010, 1'b1, 1'b1, 4'hF, AW'(10), '0);
    issue(3'b010, 1'b1, 1'b1, 4'hF, AW'(11), '0);
    check("R9 first", dout, ref_mem[10]);
    issue(3'b010, 1'b1, 1'b1, 4'hF, AW'(12), '0);
    check("R9 second", dout, ref_mem[11]);
    check("R9 drive", {35'd0, dout_drive}, 36'd1);
    idle();
    check("R9 third", dout, ref_mem[12]);

    // asynchronous output enable (R8)
    read_check("R8 setup", 5);
    out_en_n = 1'b1;
    #1;
    check("R8 masked drive", {35'd0, dout_drive}, 36'd0);
    check("R8 data held", dout, ref_mem[5]);
    out_en_n = 1'b0;
    #1;
    check("R8 redriven", {35'd0, dout_drive}, 36'd1);
    check("R8 data same", dout, ref_mem[5]);
    @(negedge clk);

    // reset keeps memory (R10)
    issue(3'b010, 1'b1, 1'b1, 4'hF, AW'(20), '0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears drive", {35'd0, dout_drive}, 36'd0);
    rst = 1'b0;
    idle();
    check("R10 no pending after reset", {35'd0, dout_drive}, 36'd0);
    read_check("R10 memory kept", 20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule